// File: doc/BRIEF.md
# Low-voltage inhibit reset controller

This block is the digital side of a supply supervisor. It receives the supply voltage as an unsigned code from an external converter. It compares that code against a pair of thresholds: a lower trip point that starts a reset and a higher recovery point that ends it. It drives a registered reset request for the system reset sequencer. It also drives a live low-supply flag that follows the comparison.

Two threshold pairs exist, one for a 3-V supply and one for a 5-V supply. A select bit picks the pair. The select is registered on every clock, and the power-on reset input clears it back to the 3-V pair. Four configuration inputs control the block:

- a power-disable bit, which switches monitoring off;
- a reset-disable bit, which keeps the flag running but blocks the reset request;
- a stop-enable bit, which keeps monitoring running while the stop-mode input is high;
- the 3-V/5-V select bit.

If the 5-V pair is chosen while the supply is not above the 5-V recovery point, the block raises a reset at once. That reset is held until the supply recovers or a power-on reset occurs.

Top module: `lvi_supervisor`

## Requirements
- R1: While `por` is high, `rst_req` is 0 and the 3-V threshold pair (falling 300, rising 330 at default parameters) is in force. This takes effect asynchronously.
- R2: With `cfg_pwr_dis` = 1, `rst_req` is 0 after the next clock edge and `low_flag` is 0 at once. Any held reset is discarded, so it does not reappear when monitoring resumes with the supply between the two thresholds.
- R3: With `stop_mode` = 1 and `cfg_stop_en` = 0, the block behaves as in R2. With `cfg_stop_en` = 1, it monitors normally during stop mode.
- R4: With `cfg_rst_dis` = 1, `rst_req` is 0 after the next edge, while `low_flag` keeps working.
- R5: While monitoring is active, `low_flag` is 1 exactly when `vdd_code` is below the falling threshold of the registered mode. It is combinational in `vdd_code`.
- R6: While monitoring is active with reset enabled, `vdd_code` below the falling threshold sets `rst_req` at the next clock edge.
- R7: Once set, `rst_req` stays 1 while `vdd_code` ≤ the rising threshold. It clears at the first edge with `vdd_code` strictly greater than the rising threshold.
- R8: `cfg_sel5v` = 1 selects the 5-V pair (falling 500, rising 550 at default parameters), and 0 selects the 3-V pair. The registered mode follows the bit at the next clock edge.
- R9: The edge after the mode becomes 5-V, `rst_req` is set if `vdd_code` ≤ the 5-V rising threshold, even when the code is above the 5-V falling threshold.
- R10: A power-on reset during a held reset releases `rst_req` and returns the block to 3-V thresholds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por | input | 1 | Power-on reset, active high, asynchronous |
| stop_mode | input | 1 | System is in stop mode |
| cfg_pwr_dis | input | 1 | Monitoring off when 1 |
| cfg_rst_dis | input | 1 | Reset request blocked when 1 |
| cfg_stop_en | input | 1 | Keep monitoring in stop mode when 1 |
| cfg_sel5v | input | 1 | 1 = 5-V thresholds, 0 = 3-V thresholds |
| vdd_code | input | VW (10) | Sampled supply voltage code |
| rst_req | output | 1 | Registered reset request |
| low_flag | output | 1 | Live low-supply flag |

## Verification
The hardest situation to reach is a held reset whose supply code lies between the falling and rising thresholds. In that window, the same input value gives different outputs depending on history. The window is also entered a second way, through a 3-V to 5-V mode switch rather than a falling supply. The stimulus reaches both paths by ramping the code down and then back up through the full range, one step per cycle, under all 32 settings of the control inputs. A bench model tracks mode, previous mode and hold state. Directed sequences then place the code exactly on each threshold, switch mode inside the 5-V window, and pulse the power-on reset while the reset is held.

// File: rtl/lvi_pkg.sv
package lvi_pkg;
   typedef enum logic {
      MODE_3V = 1'b0,
      MODE_5V = 1'b1
   } lvi_mode_e;

   localparam int NUM_MODES = 2;
endpackage

// File: rtl/lvi_trip_select.sv
module lvi_trip_select
   import lvi_pkg::*;
#(
   parameter int VW     = 10,
   parameter int FALL3  = 300,
   parameter int RISE3  = 330,
   parameter int FALL5  = 500,
   parameter int RISE5  = 550
) (
   input  lvi_mode_e         mode,
   output logic [VW-1:0]     fall_thr,
   output logic [VW-1:0]     rise_thr
);
   localparam int MAX_CODE = (1 << VW) - 1;

   logic [VW-1:0] fall_tab [NUM_MODES];
   logic [VW-1:0] rise_tab [NUM_MODES];

   if (FALL5 <= FALL3 || RISE5 <= RISE3) begin : g_bad_mode_order
      $error("5-V thresholds must lie above 3-V thresholds");
   end

   for (genvar m = 0; m < NUM_MODES; m++) begin : g_mode
      localparam int FV = (m == 0) ? FALL3 : FALL5;
      localparam int RV = (m == 0) ? RISE3 : RISE5;
      if (RV <= FV) begin : g_bad_hyst
         $error("rising threshold must exceed falling threshold");
      end
      if (RV > MAX_CODE || FV < 1) begin : g_bad_range
         $error("threshold outside code range");
      end
      assign fall_tab[m] = VW'(FV);
      assign rise_tab[m] = VW'(RV);
   end

   always_comb begin
      fall_thr = fall_tab[mode];
      rise_thr = rise_tab[mode];
   end
endmodule

// File: rtl/lvi_compare.sv
module lvi_compare #(
   parameter int VW = 10
) (
   input  logic [VW-1:0] vdd_code,
   input  logic [VW-1:0] fall_thr,
   input  logic [VW-1:0] rise_thr,
   output logic          below_fall,
   output logic          not_above_rise
);
   always_comb begin
      below_fall     = (vdd_code <  fall_thr);
      not_above_rise = (vdd_code <= rise_thr);
   end
endmodule

// File: rtl/lvi_hold_ctrl.sv
module lvi_hold_ctrl (
   input  logic clk,
   input  logic por,
   input  logic active,
   input  logic rst_dis,
   input  logic below_fall,
   input  logic not_above_rise,
   input  logic mode_rise,
   output logic hold_q
);
   logic hold_d;

   always_comb begin
      if (!active || rst_dis) begin
         hold_d = 1'b0;
      end else if (hold_q) begin
         hold_d = not_above_rise;
      end else begin
         hold_d = below_fall || (mode_rise && not_above_rise);
      end
   end

   always_ff @(posedge clk or posedge por) begin
      if (por) hold_q <= 1'b0;
      else     hold_q <= hold_d;
   end

   p_idle_clear_r2: assert property (@(posedge clk) disable iff (por)
      !active |=> !hold_q);
   p_rst_blocked_r4: assert property (@(posedge clk) disable iff (por)
      rst_dis |=> !hold_q);
   p_fall_trip_r6: assert property (@(posedge clk) disable iff (por)
      (active && !rst_dis && below_fall) |=> hold_q);
   p_hold_keep_r7: assert property (@(posedge clk) disable iff (por)
      (active && !rst_dis && hold_q && not_above_rise) |=> hold_q);
   p_release_r7: assert property (@(posedge clk) disable iff (por)
      (hold_q && !not_above_rise) |=> !hold_q);
   p_switch_trip_r9: assert property (@(posedge clk) disable iff (por)
      (active && !rst_dis && mode_rise && not_above_rise) |=> hold_q);
endmodule

// File: rtl/lvi_supervisor.sv
module lvi_supervisor
   import lvi_pkg::*;
#(
   parameter int VW    = 10,
   parameter int FALL3 = 300,
   parameter int RISE3 = 330,
   parameter int FALL5 = 500,
   parameter int RISE5 = 550
) (
   input  logic          clk,
   input  logic          por,
   input  logic          stop_mode,
   input  logic          cfg_pwr_dis,
   input  logic          cfg_rst_dis,
   input  logic          cfg_stop_en,
   input  logic          cfg_sel5v,
   input  logic [VW-1:0] vdd_code,
   output logic          rst_req,
   output logic          low_flag
);
   lvi_mode_e     mode_q;
   lvi_mode_e     mode_prev_q;
   logic          active;
   logic          mode_rise;
   logic [VW-1:0] fall_thr;
   logic [VW-1:0] rise_thr;
   logic          below_fall;
   logic          not_above_rise;
   logic          hold_q;

   // Mode register: follows the select bit, forced to 3-V by power-on reset
   always_ff @(posedge clk or posedge por) begin
      if (por) begin
         mode_q      <= MODE_3V;
         mode_prev_q <= MODE_3V;
      end else begin
         mode_q      <= lvi_mode_e'(cfg_sel5v);
         mode_prev_q <= mode_q;
      end
   end

   always_comb begin
      active    = !cfg_pwr_dis && (!stop_mode || cfg_stop_en);
      mode_rise = (mode_q == MODE_5V) && (mode_prev_q == MODE_3V);
   end

   lvi_trip_select #(
      .VW(VW), .FALL3(FALL3), .RISE3(RISE3), .FALL5(FALL5), .RISE5(RISE5)
   ) u_trip (
      .mode     (mode_q),
      .fall_thr (fall_thr),
      .rise_thr (rise_thr)
   );

   lvi_compare #(.VW(VW)) u_cmp (
      .vdd_code       (vdd_code),
      .fall_thr       (fall_thr),
      .rise_thr       (rise_thr),
      .below_fall     (below_fall),
      .not_above_rise (not_above_rise)
   );

   lvi_hold_ctrl u_hold (
      .clk            (clk),
      .por            (por),
      .active         (active),
      .rst_dis        (cfg_rst_dis),
      .below_fall     (below_fall),
      .not_above_rise (not_above_rise),
      .mode_rise      (mode_rise),
      .hold_q         (hold_q)
   );

   assign rst_req  = hold_q;
   assign low_flag = active && below_fall;

   p_mode_track_r8: assert property (@(posedge clk) disable iff (por)
      1'b1 |=> (mode_q == lvi_mode_e'($past(cfg_sel5v))));
   p_pwr_dis_quiet_r2: assert property (@(posedge clk) disable iff (por)
      cfg_pwr_dis |=> !rst_req);
   p_stop_quiet_r3: assert property (@(posedge clk) disable iff (por)
      (stop_mode && !cfg_stop_en) |=> !rst_req);
endmodule

// File: tb/lvi_supervisor_test.sv
module lvi_supervisor_test;
   localparam int CLK_P = 10;
   localparam int VW    = 10;
   localparam int F3 = 300, R3 = 330, F5 = 500, R5 = 550;

   logic clk = 1'b0;
   logic por = 1'b1;
   logic stop_mode = 0, pd = 0, rd = 0, se = 0, sel = 0;
   logic [VW-1:0] vdd = 10'd600;
   logic rst_req, low_flag;

   int checks = 0;
   int errors = 0;

   // bench model state
   bit m_mode, m_prev, m_hold;

   always #(CLK_P/2) clk = ~clk;

   lvi_supervisor #(.VW(VW)) uut (
      .clk(clk), .por(por), .stop_mode(stop_mode),
      .cfg_pwr_dis(pd), .cfg_rst_dis(rd), .cfg_stop_en(se), .cfg_sel5v(sel),
      .vdd_code(vdd), .rst_req(rst_req), .low_flag(low_flag)
   );

   function automatic bit m_active();
      return !pd && (!stop_mode || se);
   endfunction

   function automatic bit m_status();
      int f;
      f = m_mode ? F5 : F3;
      return m_active() && (int'(vdd) < f);
   endfunction

   task automatic model_step();
      int f, r;
      bit nh, rise;
      f = m_mode ? F5 : F3;
      r = m_mode ? R5 : R3;
      rise = m_mode && !m_prev;
      if (!m_active() || rd) nh = 0;
      else if (m_hold) nh = (int'(vdd) <= r);
      else nh = (int'(vdd) < f) || (rise && int'(vdd) <= r);
      m_hold = nh;
      m_prev = m_mode;
      m_mode = sel;
   endtask

   task automatic tick();
      model_step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(string req, string what, logic act, logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: got %0b expected %0b", req, what, act, exp);
      end
   endtask

   task automatic por_pulse();
      por = 1'b1;
      m_mode = 0; m_prev = 0; m_hold = 0;
      #1;
   endtask

   initial begin
      #(CLK_P * 190000);
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      m_mode = 0; m_prev = 0; m_hold = 0;
      #1;
      // R1: reset state
      chk("R1", "rst_req under por", rst_req, 1'b0);
      vdd = 10'd299;
      #1;
      chk("R1", "3-V flag under por", low_flag, 1'b1);
      @(negedge clk);
      por = 1'b0;
      vdd = 10'd600;
      tick();
      chk("R1", "rst_req after release", rst_req, 1'b0);

      // R6 / R7: falling trip and hysteresis in 3-V mode
      vdd = 10'd299; tick();
      chk("R6", "trip below 3-V fall", rst_req, 1'b1);
      chk("R5", "flag below 3-V fall", low_flag, 1'b1);
      vdd = 10'd300; #1;
      chk("R5", "flag at 3-V fall", low_flag, 1'b0);
      vdd = 10'd330; tick();
      chk("R7", "held at rising point", rst_req, 1'b1);
      vdd = 10'd331; tick();
      chk("R7", "release above rising point", rst_req, 1'b0);

      // R2: power disable clears held state
      vdd = 10'd299; tick();
      chk("R6", "trip again", rst_req, 1'b1);
      pd = 1; #1;
      chk("R2", "flag off when disabled", low_flag, 1'b0);
      tick();
      chk("R2", "rst off when disabled", rst_req, 1'b0);
      pd = 0; vdd = 10'd320; tick();
      chk("R2", "held state discarded", rst_req, 1'b0);

      // R3: stop mode
      stop_mode = 1; se = 0; vdd = 10'd100; tick();
      chk("R3", "stop without enable rst", rst_req, 1'b0);
      chk("R3", "stop without enable flag", low_flag, 1'b0);
      se = 1; tick();
      chk("R3", "stop with enable rst", rst_req, 1'b1);
      chk("R3", "stop with enable flag", low_flag, 1'b1);
      stop_mode = 0; se = 0; vdd = 10'd600; tick();
      chk("R7", "release after stop test", rst_req, 1'b0);

      // R4: reset disable
      rd = 1; vdd = 10'd100; tick();
      chk("R4", "rst blocked", rst_req, 1'b0);
      chk("R4", "flag still live", low_flag, 1'b1);
      rd = 0; vdd = 10'd600; tick();

      // R8 / R9: switch to 5-V inside the window
      vdd = 10'd520; sel = 1; tick();
      chk("R8", "flag in 5-V at 520", low_flag, 1'b0);
      chk("R9", "no rst on mode edge itself", rst_req, 1'b0);
      tick();
      chk("R9", "forced rst after switch", rst_req, 1'b1);
      vdd = 10'd550; tick();
      chk("R9", "held at 5-V rising", rst_req, 1'b1);
      vdd = 10'd551; tick();
      chk("R9", "release above 5-V rising", rst_req, 1'b0);
      vdd = 10'd450; #1;
      chk("R8", "5-V falling threshold in use", low_flag, 1'b1);
      tick();
      chk("R6", "trip below 5-V fall", rst_req, 1'b1);

      // R10: por while held
      sel = 0;
      por_pulse();
      chk("R10", "por releases rst", rst_req, 1'b0);
      chk("R10", "por reverts to 3-V", low_flag, 1'b0);
      @(negedge clk);
      por = 1'b0;
      tick();
      chk("R10", "no rst after por at 450", rst_req, 1'b0);

      // near-exhaustive sweep over all control combinations
      for (int c = 0; c < 32; c++) begin
         {pd, rd, stop_mode, se, sel} = 5'(c);
         for (int v = 1023; v >= 0; v--) begin
            vdd = VW'(v);
            tick();
            chk("R5", "sweep down flag", low_flag, m_status());
            chk("R6", "sweep down rst", rst_req, m_hold);
         end
         for (int v = 0; v < 1024; v++) begin
            vdd = VW'(v);
            tick();
            chk("R5", "sweep up flag", low_flag, m_status());
            chk("R7", "sweep up rst", rst_req, m_hold);
         end
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule